// File: doc/BRIEF.md
# Epoch-Aligned Program Start Handshake

This block lines up the moment at which two devices begin running a program. Both devices see the same epoch pulse, a one-cycle tick produced each time the shared global time counter wraps. The launching side (parent) is armed with a start vector. It then waits for an epoch tick before it does anything, so its first program cycle sits exactly on an epoch boundary. On that tick it drives the vector onto a link and raises its own start strobe.

The receiving side (child) idles and checks for an arrival once per epoch. When a vector comes in over the link, the child latches it into a one-entry buffer. On the first epoch tick strictly after the latch, it raises its start strobe and presents the buffered vector.

Because the link takes less than one epoch, the child starts exactly one epoch after the parent. This holds for any latency inside that window. Both devices therefore begin on global cycles that are known in advance. The link between the two sides is wired outside the block, which lets a system insert any path delay.

Top module: `epoch_start_align`

## Requirements
- R1: After reset, `tx_valid`, `parent_start`, `child_start` and `overrun` are all low.
- R2: Once armed, the parent sends on the first `epoch_tick` cycle strictly after the arm cycle. `tx_valid` is high for that one cycle only, and `tx_data` carries the vector latched at arm time.
- R3: `parent_start` is high in exactly the cycles in which `tx_valid` is high, and only in cycles where `epoch_tick` is high.
- R4: An `arm` request made while the parent is already waiting for its epoch is ignored. The vector that is sent is still the first one.
- R5: A vector arriving on the link (`rx_valid` high) into an empty buffer is stored. `child_start` then pulses on the first `epoch_tick` cycle strictly after the arrival cycle, and `child_vec` equals the stored vector in that cycle.
- R6: An arrival in a cycle where `epoch_tick` is high counts toward the next epoch. The child does not start in that cycle; it starts at the following tick.
- R7: An arrival while the buffer already holds an unreleased vector sets `overrun`. The flag stays high until reset, and the earlier vector is the one released.
- R8: An arrival in the same cycle as a child release is stored as a new vector and does not set `overrun`.
- R9: For any link latency of 1 to one-less-than-an-epoch cycles, `child_start` comes exactly one epoch period after `parent_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| epoch_tick | input | 1 | One-cycle pulse at each global counter wrap |
| arm | input | 1 | Request to launch a program on the parent side |
| arm_vec | input | VEC_W | Vector to send, sampled with `arm` |
| tx_valid | output | 1 | Parent link output valid |
| tx_data | output | VEC_W | Parent link output data |
| parent_start | output | 1 | Parent program start strobe |
| rx_valid | input | 1 | Child link input valid |
| rx_data | input | VEC_W | Child link input data |
| child_start | output | 1 | Child receive/start strobe |
| child_vec | output | VEC_W | Buffered vector, meaningful with `child_start` |
| overrun | output | 1 | Sticky flag: a vector arrived while the buffer was full |

## Verification
The bench builds the block with an 8-bit vector and drives an epoch tick every 16 cycles. With that short epoch, every arm phase inside an epoch can be combined with every legal link latency (1 to 15 cycles), which covers the one-epoch alignment fully. Directed cases then place arrivals on a tick, during a release, and into a full buffer, with expected cycles derived from the tick arithmetic.

// File: rtl/epoch_align_pkg.sv
package epoch_align_pkg;

    // Parent-side launch state: idle, or armed and waiting for the epoch tick.
    typedef enum logic {
        PAR_IDLE   = 1'b0,
        PAR_DESKEW = 1'b1
    } par_state_e;

endpackage

// File: rtl/align_parent.sv
module align_parent
    import epoch_align_pkg::*;
#(
    parameter int VEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             epoch_tick,
    input  logic             arm,
    input  logic [VEC_W-1:0] arm_vec,
    output logic             tx_valid,
    output logic [VEC_W-1:0] tx_data,
    output logic             start
);

    typedef struct packed {
        par_state_e       st;
        logic [VEC_W-1:0] vec;
    } par_regs_t;

    par_regs_t regs_d, regs_q;
    logic      fire;

    always_comb begin
        regs_d = regs_q;
        fire   = (regs_q.st == PAR_DESKEW) && epoch_tick;
        if (regs_q.st == PAR_IDLE && arm) begin
            regs_d.st  = PAR_DESKEW;
            regs_d.vec = arm_vec;
        end
        if (fire) begin
            regs_d.st = PAR_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{st: PAR_IDLE, vec: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign tx_valid = fire;
    assign tx_data  = regs_q.vec;
    assign start    = fire;

endmodule

// File: rtl/align_child.sv
module align_child #(
    parameter int VEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             epoch_tick,
    input  logic             rx_valid,
    input  logic [VEC_W-1:0] rx_data,
    output logic             start,
    output logic [VEC_W-1:0] vec,
    output logic             overrun
);

    typedef struct packed {
        logic             full;
        logic [VEC_W-1:0] buffer;
        logic             ovr;
    } chd_regs_t;

    chd_regs_t regs_d, regs_q;
    logic      release_now;
    logic      accept;

    always_comb begin
        regs_d      = regs_q;
        // A buffer filled in an earlier cycle is released on this tick.
        release_now = regs_q.full && epoch_tick;
        accept      = rx_valid && (!regs_q.full || release_now);
        if (release_now) begin
            regs_d.full = 1'b0;
        end
        if (accept) begin
            regs_d.full   = 1'b1;
            regs_d.buffer = rx_data;
        end
        if (rx_valid && !accept) begin
            regs_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{full: 1'b0, buffer: '0, ovr: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign start   = release_now;
    assign vec     = regs_q.buffer;
    assign overrun = regs_q.ovr;

endmodule

// File: rtl/epoch_start_align.sv
module epoch_start_align #(
    parameter int VEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             epoch_tick,
    input  logic             arm,
    input  logic [VEC_W-1:0] arm_vec,
    output logic             tx_valid,
    output logic [VEC_W-1:0] tx_data,
    output logic             parent_start,
    input  logic             rx_valid,
    input  logic [VEC_W-1:0] rx_data,
    output logic             child_start,
    output logic [VEC_W-1:0] child_vec,
    output logic             overrun
);

    align_parent #(.VEC_W(VEC_W)) u_parent (
        .clk        (clk),
        .rst_n      (rst_n),
        .epoch_tick (epoch_tick),
        .arm        (arm),
        .arm_vec    (arm_vec),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .start      (parent_start)
    );

    align_child #(.VEC_W(VEC_W)) u_child (
        .clk        (clk),
        .rst_n      (rst_n),
        .epoch_tick (epoch_tick),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .start      (child_start),
        .vec        (child_vec),
        .overrun    (overrun)
    );

endmodule

// File: rtl/epoch_start_align_chk.sv
module epoch_start_align_chk (
    input logic clk,
    input logic rst_n,
    input logic epoch_tick,
    input logic tx_valid,
    input logic parent_start,
    input logic rx_valid,
    input logic child_start,
    input logic overrun
);

    assert_send_on_epoch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> epoch_tick);

    assert_start_with_send_R3: assert property (@(posedge clk) disable iff (!rst_n)
        parent_start |-> tx_valid);

    assert_send_with_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> parent_start);

    assert_single_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        parent_start |=> !parent_start);

    assert_child_on_epoch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        child_start |-> epoch_tick);

    assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_valid));

endmodule

bind epoch_start_align epoch_start_align_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .epoch_tick   (epoch_tick),
    .tx_valid     (tx_valid),
    .parent_start (parent_start),
    .rx_valid     (rx_valid),
    .child_start  (child_start),
    .overrun      (overrun)
);

// File: tb/test_epoch_start_align.sv
module test_epoch_start_align;

    localparam int VW = 8;
    localparam int EP = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          epoch_tick;
    logic          arm;
    logic [VW-1:0] arm_vec;
    logic          tx_valid;
    logic [VW-1:0] tx_data;
    logic          parent_start;
    logic          rx_valid;
    logic [VW-1:0] rx_data;
    logic          child_start;
    logic [VW-1:0] child_vec;
    logic          overrun;

    int n_checks = 0;
    int n_fails  = 0;
    int n        = 0;
    int last_n   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    epoch_start_align #(.VEC_W(VW)) i_epoch_start_align (
        .clk          (clk),
        .rst_n        (rst_n),
        .epoch_tick   (epoch_tick),
        .arm          (arm),
        .arm_vec      (arm_vec),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .parent_start (parent_start),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .child_start  (child_start),
        .child_vec    (child_vec),
        .overrun      (overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: drive inputs at negedge, epoch from global count, then sample.
    task automatic step(input logic a, input logic [VW-1:0] av,
                        input logic rv, input logic [VW-1:0] rd);
        @(negedge clk);
        arm        = a;
        arm_vec    = av;
        rx_valid   = rv;
        rx_data    = rd;
        epoch_tick = (n % EP == 0);
        #1;
        last_n = n;
        n++;
    endtask

    task automatic idle();
        step(1'b0, '0, 1'b0, '0);
    endtask

    task automatic to_phase(input int p);
        while (n % EP != p) idle();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) idle();
        rst_n = 1'b1;
    endtask

    // Wait for child_start; check it falls on cycle exp_n with vector exp_v.
    task automatic wait_child(input int exp_n, input logic [VW-1:0] exp_v, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 3 * EP; i++) begin
            idle();
            if (child_start) begin
                seen = 1'b1;
                break;
            end
        end
        chk(seen && last_n == exp_n, req, last_n, exp_n);
        chk(child_vec == exp_v, req, int'(child_vec), int'(exp_v));
    endtask

    initial begin
        arm = 0; arm_vec = '0; rx_valid = 0; rx_data = '0; epoch_tick = 0;
        do_reset();
        idle();
        // R1 reset state
        chk(!tx_valid && !parent_start, "R1", int'(tx_valid), 0);
        chk(!child_start && !overrun, "R1", int'(overrun), 0);

        // R2/R3/R5/R9 sweep: every arm phase x every latency below one epoch
        for (int off = 0; off < EP; off++) begin
            for (int lat = 1; lat < EP; lat++) begin
                logic [VW-1:0] v;
                int arm_n, exp_p, p_n;
                bit sent;
                v = VW'(off * 16 + lat);
                to_phase(off);
                step(1'b1, v, 1'b0, '0);
                arm_n = last_n;
                exp_p = arm_n - (arm_n % EP) + EP;
                sent = 1'b0;
                for (int i = 0; i < 3 * EP; i++) begin
                    idle();
                    if (tx_valid) begin
                        sent = 1'b1;
                        break;
                    end
                end
                p_n = last_n;
                chk(sent && p_n == exp_p, "R2", p_n, exp_p);
                chk(tx_data == v, "R2", int'(tx_data), int'(v));
                chk(parent_start == 1'b1, "R3", int'(parent_start), 1);
                for (int i = 1; i < lat; i++) idle();
                step(1'b0, '0, 1'b1, tx_data);
                chk(!tx_valid, "R2", int'(tx_valid), 0);
                wait_child(p_n + EP, v, "R9");
                chk(!overrun, "R7", int'(overrun), 0);
            end
        end

        // R4: second arm during deskew is ignored
        to_phase(3);
        step(1'b1, 8'hA5, 1'b0, '0);
        step(1'b1, 8'h3C, 1'b0, '0);
        to_phase(0);
        idle();
        chk(tx_valid && tx_data == 8'hA5, "R4", int'(tx_data), 8'hA5);
        idle();
        chk(!tx_valid, "R4", int'(tx_valid), 0);

        // R6: arrival exactly on an epoch tick
        to_phase(0);
        step(1'b0, '0, 1'b1, 8'h5A);
        begin
            int a_n;
            a_n = last_n;
            chk(!child_start, "R6", int'(child_start), 0);
            wait_child(a_n + EP, 8'h5A, "R6");
        end

        // R8: arrival in the release cycle is kept, no overrun
        to_phase(5);
        step(1'b0, '0, 1'b1, 8'h11);
        to_phase(0);
        step(1'b0, '0, 1'b1, 8'h22);
        chk(child_start && child_vec == 8'h11, "R8", int'(child_vec), 8'h11);
        begin
            int r_n;
            r_n = last_n;
            idle();
            chk(!overrun, "R8", int'(overrun), 0);
            wait_child(r_n + EP, 8'h22, "R8");
        end

        // R7: second arrival while full sets sticky overrun, first kept
        to_phase(4);
        step(1'b0, '0, 1'b1, 8'h77);
        idle();
        chk(!overrun, "R7", int'(overrun), 0);
        step(1'b0, '0, 1'b1, 8'h88);
        idle();
        chk(overrun, "R7", int'(overrun), 1);
        begin
            int exp_n;
            exp_n = n - (n % EP) + EP;
            wait_child(exp_n, 8'h77, "R7");
        end
        repeat (EP) idle();
        chk(overrun, "R7", int'(overrun), 1);
        do_reset();
        idle();
        chk(!overrun, "R1", int'(overrun), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule